// File: doc/BRIEF.md
# Filtered Idle-Pin Powerdown Requester

This block watches a small group of general-purpose input pins coming from an external device on a local bus. The host decides when that device may be put to sleep. For each pin, a polarity bit says which level would raise that pin's interrupt. The opposite level therefore means the device has nothing to report. When every enabled pin has sat at its quiet level long enough, the block raises a powerdown request toward the host.

The pins are first brought into the local clock domain. A filter then requires the quiet condition to last for a programmable run of 2^N clock cycles, where N is a 4-bit field. Any departure from the quiet condition restarts the run. When the run completes, a sticky request flag is set and a one-cycle interrupt pulse is produced. The host clears the flag by writing one. The block does not raise a new request until the quiet condition has first been broken.

Top module: `pdreq_gen`

## Requirements
- R1: While reset is asserted, and after it is released, both `pd_req_o` and `pd_irq_o` are low until a request is raised.
- R2: A pin whose bit in `pin_en_i` is 0 takes no part. With no pin enabled, no request is ever raised.
- R3: For an enabled pin i, the quiet level is the inverse of `pin_pol_i[i]`. Polarity 1 means a high pin asserts the interrupt, so low is quiet. Polarity 0 means high is quiet.
- R4: `pd_req_o` rises at the (2^N + 2)th rising edge after the edge where the pins reach the quiet state, with N = `period_i`. Two of those edges are the input synchronizer. N = 0 gives 3 edges.
- R5: Leaving the quiet state on any enabled pin, even for one cycle, restarts the count. The full 2^N run is then needed again after the pins return.
- R6: `pd_irq_o` is high for exactly one cycle, the first cycle in which `pd_req_o` is high.
- R7: `pd_req_o` stays high until `req_clr_i` is high at a rising edge, which clears it.
- R8: After a request, no further request is raised while the quiet condition continues, even if the flag is cleared. A new request needs the condition to break and then hold again for 2^N cycles.
- R9: If a request is raised at the same edge where `req_clr_i` is high, the flag ends up set.
- R10: With several pins enabled, the quiet condition needs all enabled pins to be quiet together.
- R11: Toggling a disabled pin while the enabled pins are quiet does not disturb the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 2 | Raw general-purpose pins from the external device |
| pin_en_i | input | 2 | Per-pin participation enable |
| pin_pol_i | input | 2 | Per-pin interrupt level (1 = high asserts) |
| period_i | input | 4 | Filter exponent N, run length 2^N cycles |
| req_clr_i | input | 1 | Write-one-to-clear strobe for the request flag |
| pd_req_o | output | 1 | Sticky powerdown request flag |
| pd_irq_o | output | 1 | One-cycle interrupt pulse on request |

## Verification
The embedded properties assume that the enable, polarity and period inputs are static while any pin is enabled. A filter count held against one period must not be judged against another. The bench follows this rule by changing configuration only through a step that first disables every pin. It then waits several cycles, writes the new polarity and period, and re-enables the pins. Pins and the clear strobe are driven freely, including a clear on the exact edge of a new request.

// File: rtl/pdreq_pkg.sv
package pdreq_pkg;

  localparam int unsigned PD_NPINS  = 2;
  localparam int unsigned PD_PER_W  = 4;
  localparam int unsigned PD_SYNC_N = 2;

  // Filter sequencing: waiting for quiet, counting quiet run, request spent
  typedef enum logic [1:0] {
    FLT_WAIT  = 2'd0,
    FLT_RUN   = 2'd1,
    FLT_SPENT = 2'd2
  } flt_state_e;

endpackage

// File: rtl/pdreq_rst_sync.sv
module pdreq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] rq_q;
  logic [STAGES-1:0] rq_d;

  always_comb begin
    rq_d = {rq_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rq_q <= '0;
    end else begin
      rq_q <= rq_d;
    end
  end

  assign rst_sync_no = rq_q[STAGES-1];

endmodule

// File: rtl/pdreq_pin_sync.sv
module pdreq_pin_sync #(
  parameter int unsigned NPINS  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] pin_s_o
);

  for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], pin_i[gi]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign pin_s_o[gi] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/pdreq_idle_filter.sv
module pdreq_idle_filter
  import pdreq_pkg::*;
#(
  parameter int unsigned NPINS = 2,
  parameter int unsigned PER_W = 4,
  localparam int unsigned CNT_W = 1 << PER_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_s_i,
  input  logic [NPINS-1:0] pin_en_i,
  input  logic [NPINS-1:0] pin_pol_i,
  input  logic [PER_W-1:0] period_i,
  output logic             quiet_o,
  output logic             fire_o
);

  logic [NPINS-1:0] pin_ok;
  logic [CNT_W-1:0] tgt_m1;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  flt_state_e       st_q, st_d;

  // A pin is fine when disabled or sitting at the inverse of its interrupt level
  for (genvar gi = 0; gi < NPINS; gi++) begin : g_ok
    assign pin_ok[gi] = ~pin_en_i[gi] | (pin_s_i[gi] ^ pin_pol_i[gi]);
  end

  assign quiet_o = (|pin_en_i) & (&pin_ok);
  assign tgt_m1  = (CNT_W'(1) << period_i) - CNT_W'(1);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    fire_o = 1'b0;
    if (!quiet_o) begin
      st_d   = FLT_WAIT;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        FLT_WAIT, FLT_RUN: begin
          if (cnt_q == tgt_m1) begin
            fire_o = 1'b1;
            st_d   = FLT_SPENT;
          end else begin
            cnt_d  = cnt_q + CNT_W'(1);
            cnt_en = 1'b1;
            st_d   = FLT_RUN;
          end
        end
        FLT_SPENT: begin
          st_d = FLT_SPENT;
        end
        default: begin
          st_d = FLT_WAIT;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= FLT_WAIT;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R4: the run counter never passes the programmed length
  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= tgt_m1);

  // R5: losing the quiet state clears the run
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !quiet_o |=> (cnt_q == '0) && (st_q == FLT_WAIT));

  // R8: a fire is never followed by another without a break
  p_single_fire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

endmodule

// File: rtl/pdreq_req_flag.sv
module pdreq_req_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);

  logic flag_q, flag_d, flag_en;
  logic irq_q, irq_d;

  always_comb begin
    flag_en = fire_i | clr_i;
    flag_d  = fire_i;        // set has priority over clear
    irq_d   = fire_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R7: the flag survives any cycle without a clear
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  // R9: a fire always leaves the flag set, clear or not
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> flag_o);

  // R6: the interrupt only accompanies a set flag and lasts one cycle
  p_irq_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
  p_irq_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

endmodule

// File: rtl/pdreq_gen.sv
module pdreq_gen
  import pdreq_pkg::*;
#(
  parameter int unsigned NPINS  = PD_NPINS,
  parameter int unsigned PER_W  = PD_PER_W,
  parameter int unsigned SYNC_N = PD_SYNC_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] pin_en_i,
  input  logic [NPINS-1:0] pin_pol_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             req_clr_i,
  output logic             pd_req_o,
  output logic             pd_irq_o
);

  logic             rst_int_n;
  logic [NPINS-1:0] pin_s;
  logic             quiet;
  logic             fire;

  pdreq_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  pdreq_pin_sync #(.NPINS(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .pin_i   (pin_i),
    .pin_s_o (pin_s)
  );

  pdreq_idle_filter #(.NPINS(NPINS), .PER_W(PER_W)) u_filt (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .pin_s_i   (pin_s),
    .pin_en_i  (pin_en_i),
    .pin_pol_i (pin_pol_i),
    .period_i  (period_i),
    .quiet_o   (quiet),
    .fire_o    (fire)
  );

  pdreq_req_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .fire_i (fire),
    .clr_i  (req_clr_i),
    .flag_o (pd_req_o),
    .irq_o  (pd_irq_o)
  );

  // R2: with every pin disabled no interrupt can follow
  p_no_en_r2: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (pin_en_i == '0) |=> !pd_irq_o);

  // R4: a new interrupt is only ever preceded by a quiet cycle
  p_irq_after_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $rose(pd_irq_o) |-> $past(quiet));

  // R1: reset leaves both outputs low
  always_comb begin
    if (!rst_ni) begin
      p_reset_low_r1: assert (!pd_req_o && !pd_irq_o);
    end
  end

endmodule

// File: tb/tb_pdreq_gen.sv
`timescale 1ns/1ps
module tb_pdreq_gen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] pins, en, pol;
  logic [3:0] per;
  logic       clr;
  logic       pd_req, pd_irq;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  pdreq_gen dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .pin_i     (pins),
    .pin_en_i  (en),
    .pin_pol_i (pol),
    .period_i  (per),
    .req_clr_i (clr),
    .pd_req_o  (pd_req),
    .pd_irq_o  (pd_irq)
  );

  // Behavioural reference: delayed pin samples, quiet-run length, armed bit
  logic [1:0] m_rq;
  logic [1:0] m_p1, m_p2;
  int         m_run;
  bit         m_armed, m_flag, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rq = 2'b00; m_p1 = 2'b00; m_p2 = 2'b00;
      m_run = 0; m_armed = 1'b1; m_flag = 1'b0; m_irq = 1'b0;
    end else begin
      if (!m_rq[1]) begin
        m_p1 = 2'b00; m_p2 = 2'b00;
        m_run = 0; m_armed = 1'b1; m_flag = 1'b0; m_irq = 1'b0;
      end else begin
        bit quiet_now, fire_now;
        int len;
        len = 1 << per;
        quiet_now = (en != 2'b00);
        for (int i = 0; i < 2; i++)
          if (en[i] && (m_p2[i] == pol[i])) quiet_now = 1'b0;
        fire_now = quiet_now && m_armed && (m_run >= len - 1);
        m_irq  = fire_now;
        if (fire_now) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        if (!quiet_now) begin
          m_armed = 1'b1; m_run = 0;
        end else begin
          if (fire_now) m_armed = 1'b0;
          if (m_run < len - 1) m_run = m_run + 1;
        end
        m_p2 = m_p1; m_p1 = pins;
      end
      m_rq = {m_rq[0], 1'b1};
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference (R4 R6 R7 R8)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(pd_req == m_flag, "R4/R7/R8 model flag", pd_req, m_flag);
      chk(pd_irq == m_irq,  "R6 model irq",        pd_irq, m_irq);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] e, input logic [1:0] p, input logic [3:0] n);
    en = 2'b00;
    tick(4);
    pol = p; per = n;
    tick(1);
    en = e;
  endtask

  task automatic clr_pulse();
    clr = 1'b1; tick(1); clr = 1'b0;
  endtask

  task automatic want(input string req, input bit f);
    chk(pd_req == f, req, pd_req, f);
  endtask

  initial begin
    rst_n = 1'b0; pins = 2'b00; en = 2'b00; pol = 2'b11; per = 4'd0; clr = 1'b0;
    tick(3);
    want("R1 reset flag", 1'b0);
    chk(pd_irq == 1'b0, "R1 reset irq", pd_irq, 0);
    rst_n = 1'b1;
    tick(4);
    cmp_on = 1'b1;
    want("R1 after release", 1'b0);

    // R2: quiet levels on all pins but nothing enabled
    pins = 2'b00;
    tick(20);
    want("R2 no pin enabled", 1'b0);

    // R4: N=0, pin0 active-high, quiet low
    pins = 2'b01;
    cfg(2'b01, 2'b01, 4'd0);
    tick(4); clr_pulse(); tick(2);
    pins = 2'b00;
    tick(2);  want("R4 N=0 early", 1'b0);
    tick(1);  want("R4 N=0 raised", 1'b1);
    chk(pd_irq == 1'b1, "R6 irq with rise", pd_irq, 1);
    tick(1);
    chk(pd_irq == 1'b0, "R6 irq one cycle", pd_irq, 0);
    want("R7 held", 1'b1);

    // R3: pin0 active-low, so high is quiet, N=2
    pins = 2'b00;
    cfg(2'b01, 2'b00, 4'd2);
    tick(4); clr_pulse(); tick(2);
    want("R7 cleared", 1'b0);
    pins = 2'b01;
    tick(5);  want("R3 inverse early", 1'b0);
    tick(1);  want("R3 inverse raised", 1'b1);

    // R5: glitch restarts a N=3 run
    pins = 2'b01;
    cfg(2'b01, 2'b01, 4'd3);
    tick(4); clr_pulse(); tick(2);
    pins = 2'b00; tick(5);
    pins = 2'b01; tick(1);
    pins = 2'b00;
    tick(9);  want("R5 restarted early", 1'b0);
    tick(1);  want("R5 restarted raised", 1'b1);

    // R8: no re-raise while quiet persists
    clr_pulse();
    tick(40); want("R8 no rearm", 1'b0);
    pins = 2'b01; tick(3);
    pins = 2'b00;
    tick(10); want("R8 rearmed", 1'b1);

    // R9: clear on the edge of a new request
    clr_pulse(); tick(2);
    pins = 2'b01; tick(3);
    pins = 2'b00;
    tick(9);
    clr = 1'b1; tick(1); clr = 1'b0;
    want("R9 set beats clear", 1'b1);
    clr_pulse();
    want("R7 clear works", 1'b0);

    // R10: both pins enabled; pin1 active-high, pin0 active-low, N=1
    pins = 2'b10;
    cfg(2'b11, 2'b10, 4'd1);
    tick(4); clr_pulse(); tick(2);
    pins = 2'b11;
    tick(20); want("R10 one pin busy", 1'b0);
    pins = 2'b01;
    tick(3);  want("R10 all quiet early", 1'b0);
    tick(1);  want("R10 all quiet raised", 1'b1);

    // R11: disabled pin1 toggles during N=4 run
    pins = 2'b01;
    cfg(2'b01, 2'b01, 4'd4);
    tick(4); clr_pulse(); tick(2);
    pins = 2'b00;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      pins[1] = ~pins[1];
      if (i == 16) want("R11 toggle early", 1'b0);
      if (i == 17) want("R11 toggle raised", 1'b1);
    end

    // R4: long run, N=10
    pins = 2'b01;
    cfg(2'b01, 2'b01, 4'd10);
    tick(4); clr_pulse(); tick(2);
    pins = 2'b00;
    tick(1025); want("R4 N=10 early", 1'b0);
    tick(1);    want("R4 N=10 raised", 1'b1);

    tick(5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule